// File: doc/BRIEF.md
# Synchronized Serial Debug Port

This block is the target end of a slow, clocked serial debug link. An external host drives a debug clock and a serial data line. The block samples both into the processor clock domain and passes the debug clock through a level filter. It acts only on rising edges of that filtered clock. On each such edge it takes in one data bit and moves its serial output on to the next bit.

Traffic is framed in fixed packets of one status bit followed by a data field, sent most significant bit first. When a packet is complete, it is handed to the command logic behind the port with a one-cycle strobe. In the same cycle the port loads the word it will return during the next packet. That word is either a response waiting at the command interface or a "not ready" pattern.

A lock input silences the port. While it is high, the debug clock and data are ignored, no packet is delivered, and the serial output sits at its idle level.

Top module: `dbg_serial_port`

## Requirements
- R1: A synchronous reset forces the serial output to 0, clears the delivered packet outputs to 0 and holds the packet strobe and response acknowledge low. It also clears the bit counter, so a partly received packet is discarded.
- R2: A debug clock high for a single processor cycle is not taken as an edge. A level counts only when seen on two consecutive processor clock samples.
- R3: A packet is 17 bits. The first bit received becomes `pkt_stat_o`, and the next 16 bits form `pkt_data_o`, most significant bit first.
- R4: After the 17th accepted rising edge, `pkt_valid_o` is high for exactly one processor cycle. It is never high in any other cycle.
- R5: A pending response loaded at the end of a packet is shifted out during the next packet, one bit per accepted rising edge: the status bit first, then the data most significant bit first.
- R6: If no response is pending at the end of a packet, the next packet returns the not-ready pattern. That pattern is a 1 followed by sixteen 0s.
- R7: `rsp_ack_o` pulses for one cycle, together with `pkt_valid_o`, exactly when a pending response was loaded. It stays low when none was pending.
- R8: `dbg_dout_o` comes from a register and changes only in the cycle after an accepted rising edge or while the lock is applied. It holds steady while the debug clock is low.
- R9: While `secure_i` is high, `dbg_dout_o` is 0 and no packet is delivered. Debug clock and data activity has no effect: the bit count and received bits are kept, and a packet resumes after release.
- R10: The first packet after reset returns all zeros on `dbg_dout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_clk_i | input | 1 | Asynchronous debug clock from host |
| dbg_din_i | input | 1 | Asynchronous serial data from host |
| secure_i | input | 1 | Lock: port ignores host while high |
| rsp_pend_i | input | 1 | A response word is waiting |
| rsp_stat_i | input | 1 | Status bit of the waiting response |
| rsp_data_i | input | 16 | Data field of the waiting response |
| rsp_ack_o | output | 1 | Pulse: waiting response was loaded |
| pkt_valid_o | output | 1 | Pulse: a full packet was received |
| pkt_stat_o | output | 1 | Status bit of the last packet |
| pkt_data_o | output | 16 | Data field of the last packet |
| dbg_dout_o | output | 1 | Registered serial output to host |

## Verification
The single-cycle strobe property depends on accepted debug clock edges being at least two processor cycles apart. This holds only when the host clock stays at or below one fifth of the processor rate. The bench therefore holds each debug clock phase for five processor cycles, and its only deliberately short pulses are the one-cycle glitches that the filter must reject.

The properties also assume that the host changes data during the low phase, well before the filtered rise. The bench sets each bit at the falling edge for this reason. Lock is applied and released only while the debug clock is held steady, so no edge straddles the change.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

   localparam int DEF_DATA_W = 16;
   localparam int DEF_SYNC   = 2;
   localparam int DEF_FILT   = 2;

   // Width of a counter that counts 0 .. n-1.
   function automatic int cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_i,
   output logic sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dsp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dsp_edge.sv
module dsp_edge #(
   parameter int FILT = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic lvl_i,
   output logic rise_o
);

   if (FILT < 1) begin : g_bad_filt
      $error("dsp_edge: FILT must be at least 1");
   end

   logic [FILT-1:0] win;
   logic            acc_q;
   logic            steady;

   if (FILT == 1) begin : g_nofilt
      assign win = lvl_i;
   end else if (FILT == 2) begin : g_filt2
      logic hist_q;
      always_ff @(posedge clk) begin
         if (rst) hist_q <= 1'b0;
         else     hist_q <= lvl_i;
      end
      assign win = {hist_q, lvl_i};
   end else begin : g_filtn
      logic [FILT-2:0] hist_q;
      always_ff @(posedge clk) begin
         if (rst) hist_q <= '0;
         else     hist_q <= {hist_q[FILT-3:0], lvl_i};
      end
      assign win = {hist_q, lvl_i};
   end

   assign steady = (&win) | ~(|win);

   always_ff @(posedge clk) begin
      if (rst)         acc_q <= 1'b0;
      else if (steady) acc_q <= lvl_i;
   end

   assign rise_o = steady & lvl_i & ~acc_q;

endmodule

// File: rtl/dsp_frame.sv
module dsp_frame
   import dsp_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter bit IDLE_LVL = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rise_i,
   input  logic              din_i,
   input  logic              lock_i,
   input  logic              pend_i,
   input  logic [DATA_W:0]   rsp_i,
   output logic              ack_o,
   output logic              pv_o,
   output logic [DATA_W:0]   pkt_o,
   output logic              dout_o
);

   localparam int            FW        = DATA_W + 1;
   localparam int            CW        = cnt_w(FW);
   localparam logic [CW-1:0] LAST      = CW'(FW - 1);
   localparam logic [FW-1:0] NOT_READY = {1'b1, {DATA_W{1'b0}}};

   if (DATA_W < 1) begin : g_bad_width
      $error("dsp_frame: DATA_W must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic [FW-1:0] rx_q, tx_q, pkt_q;
   logic [FW-1:0] rx_next;
   logic          dout_q, pv_q, ack_q;

   assign rx_next = {rx_q[FW-2:0], din_i};

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         rx_q   <= '0;
         tx_q   <= '0;
         pkt_q  <= '0;
         dout_q <= IDLE_LVL;
         pv_q   <= 1'b0;
         ack_q  <= 1'b0;
      end else begin
         pv_q  <= 1'b0;
         ack_q <= 1'b0;
         if (lock_i) begin
            dout_q <= IDLE_LVL;
         end else if (rise_i) begin
            dout_q <= tx_q[FW-1];
            rx_q   <= rx_next;
            if (cnt_q == LAST) begin
               cnt_q <= '0;
               pkt_q <= rx_next;
               pv_q  <= 1'b1;
               if (pend_i) begin
                  tx_q  <= rsp_i;
                  ack_q <= 1'b1;
               end else begin
                  tx_q  <= NOT_READY;
               end
            end else begin
               cnt_q <= cnt_q + CW'(1);
               tx_q  <= tx_q << 1;
            end
         end
      end
   end

   assign dout_o = dout_q;
   assign pv_o   = pv_q;
   assign ack_o  = ack_q;
   assign pkt_o  = pkt_q;

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
   import dsp_pkg::*;
#(
   parameter int DATA_W = DEF_DATA_W,
   parameter int SYNC   = DEF_SYNC,
   parameter int FILT   = DEF_FILT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dbg_clk_i,
   input  logic              dbg_din_i,
   input  logic              secure_i,
   input  logic              rsp_pend_i,
   input  logic              rsp_stat_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic              rsp_ack_o,
   output logic              pkt_valid_o,
   output logic              pkt_stat_o,
   output logic [DATA_W-1:0] pkt_data_o,
   output logic              dbg_dout_o
);

   logic          clk_s, din_s, rise_raw, rise_ok;
   logic [DATA_W:0] pkt_w;

   dsp_sync #(.STAGES(SYNC)) i_sync_clk (
      .clk(clk), .rst(rst), .async_i(dbg_clk_i), .sync_o(clk_s));

   dsp_sync #(.STAGES(SYNC)) i_sync_din (
      .clk(clk), .rst(rst), .async_i(dbg_din_i), .sync_o(din_s));

   dsp_edge #(.FILT(FILT)) i_edge (
      .clk(clk), .rst(rst), .lvl_i(clk_s), .rise_o(rise_raw));

   assign rise_ok = rise_raw & ~secure_i;

   dsp_frame #(.DATA_W(DATA_W)) i_frame (
      .clk    (clk),
      .rst    (rst),
      .rise_i (rise_ok),
      .din_i  (din_s),
      .lock_i (secure_i),
      .pend_i (rsp_pend_i),
      .rsp_i  ({rsp_stat_i, rsp_data_i}),
      .ack_o  (rsp_ack_o),
      .pv_o   (pkt_valid_o),
      .pkt_o  (pkt_w),
      .dout_o (dbg_dout_o)
   );

   assign pkt_stat_o = pkt_w[DATA_W];
   assign pkt_data_o = pkt_w[DATA_W-1:0];

endmodule

// File: rtl/dsp_chk.sv
module dsp_chk (
   input logic clk,
   input logic rst,
   input logic secure,
   input logic vrise,
   input logic dout,
   input logic pv,
   input logic ack
);

   // R4
   pv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      pv |=> !pv);

   // R4
   pv_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
      !vrise |=> !pv);

   // R7
   ack_with_pkt_chk: assert property (@(posedge clk) disable iff (rst)
      ack |-> pv);

   // R9
   lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      secure |=> (!dout && !pv && !ack));

   // R8
   dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!vrise && !secure) |=> $stable(dout));

endmodule

bind dbg_serial_port dsp_chk i_chk (
   .clk    (clk),
   .rst    (rst),
   .secure (secure_i),
   .vrise  (rise_ok),
   .dout   (dbg_dout_o),
   .pv     (pkt_valid_o),
   .ack    (rsp_ack_o)
);

// File: tb/test_dbg_serial_port.sv
module test_dbg_serial_port;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        dbg_clk = 1'b0;
   logic        dbg_din = 1'b0;
   logic        secure = 1'b0;
   logic        pend = 1'b0;
   logic [16:0] rsp = '0;
   logic        ack, pv, pstat, dout;
   logic [15:0] pdata;

   int checks = 0;
   int errors = 0;
   int pv_n = 0;
   int ack_n = 0;
   logic [16:0] last_pkt = '0;
   bit done = 0;

   always #4 clk = ~clk;

   dbg_serial_port i_dbg_serial_port (
      .clk(clk), .rst(rst), .dbg_clk_i(dbg_clk), .dbg_din_i(dbg_din),
      .secure_i(secure), .rsp_pend_i(pend), .rsp_stat_i(rsp[16]),
      .rsp_data_i(rsp[15:0]), .rsp_ack_o(ack), .pkt_valid_o(pv),
      .pkt_stat_o(pstat), .pkt_data_o(pdata), .dbg_dout_o(dout));

   always @(negedge clk) begin
      if (pv) begin
         pv_n++;
         last_pkt = {pstat, pdata};
      end
      if (ack) ack_n++;
   end

   // {host word, pending, response word}
   localparam logic [34:0] VEC [6] = '{
      {17'h1A5C3, 1'b1, 17'h01234},
      {17'h0FFFF, 1'b0, 17'h00000},
      {17'h10001, 1'b1, 17'h18001},
      {17'h08000, 1'b1, 17'h0FFFF},
      {17'h15555, 1'b0, 17'h00000},
      {17'h00000, 1'b1, 17'h1AAAA}
   };

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, output logic o, output bit held);
      logic d0;
      dbg_din = b;
      dbg_clk = 1'b0;
      cyc(1);
      d0 = dout;
      cyc(4);
      held = (dout == d0);
      dbg_clk = 1'b1;
      cyc(5);
      o = dout;
   endtask

   task automatic send_bits(input logic [16:0] w, input int hi, input int lo,
                            output logic [16:0] got, output int bad_hold);
      logic o;
      bit h;
      bad_hold = 0;
      got = '0;
      for (int b = hi; b >= lo; b--) begin
         send_bit(w[b], o, h);
         got[b] = o;
         if (!h) bad_hold++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [16:0] got, exp_out, prev_rsp, w;
      int bad, pv0, ack0, dout_bad;
      bit prev_pend;

      cyc(3);
      rst = 1'b0;
      cyc(1);
      // R1 reset state
      check(dout == 1'b0, "R1 dout", 32'(dout), 0);
      check(pv == 1'b0 && ack == 1'b0, "R1 strobes", 32'({pv, ack}), 0);
      check({pstat, pdata} == 17'h0, "R1 pkt", 32'({pstat, pdata}), 0);

      prev_pend = 1'b0;
      prev_rsp  = '0;
      for (int i = 0; i < 6; i++) begin
         pend = VEC[i][17];
         rsp  = VEC[i][16:0];
         pv0 = pv_n;
         ack0 = ack_n;
         send_bits(VEC[i][34:18], 16, 0, got, bad);
         if (i == 0) exp_out = '0;
         else        exp_out = prev_pend ? prev_rsp : 17'h10000;
         // R3 packet content, R4 single strobe
         check(last_pkt == VEC[i][34:18], "R3 packet", 32'(last_pkt), 32'(VEC[i][34:18]));
         check(pv_n == pv0 + 1, "R4 strobe count", 32'(pv_n - pv0), 1);
         // R7 acknowledge only when pending
         check(ack_n == ack0 + int'(VEC[i][17]), "R7 ack", 32'(ack_n - ack0), 32'(VEC[i][17]));
         // R5 response / R6 not ready / R10 first frame zeros
         check(got == exp_out, i == 0 ? "R10 first out" : (prev_pend ? "R5 response out" : "R6 not ready"),
               32'(got), 32'(exp_out));
         // R8 output stable during low phase
         check(bad == 0, "R8 hold", 32'(bad), 0);
         prev_pend = VEC[i][17];
         prev_rsp  = VEC[i][16:0];
      end

      // R9 lock mid-packet
      pend = 1'b0;
      w = 17'h13C5A;
      pv0 = pv_n;
      ack0 = ack_n;
      send_bits(w, 16, 9, got, bad);
      secure = 1'b1;
      cyc(2);
      dout_bad = 0;
      for (int j = 0; j < 10; j++) begin
         logic o;
         bit h;
         send_bit(j[0], o, h);
         if (dout !== 1'b0) dout_bad++;
      end
      dbg_clk = 1'b0;
      cyc(5);
      check(dout_bad == 0 && dout == 1'b0, "R9 idle output", 32'(dout_bad), 0);
      check(pv_n == pv0, "R9 no packet", 32'(pv_n - pv0), 0);
      secure = 1'b0;
      cyc(3);
      send_bits(w, 8, 0, got, bad);
      check(pv_n == pv0 + 1 && last_pkt == w, "R9 resume", 32'(last_pkt), 32'(w));
      check(ack_n == ack0, "R7 no ack idle", 32'(ack_n - ack0), 0);

      // R2 one-cycle glitches ignored
      w = 17'h0B6E1;
      pv0 = pv_n;
      send_bits(w, 16, 12, got, bad);
      dbg_clk = 1'b0;
      cyc(5);
      for (int g = 0; g < 3; g++) begin
         dbg_clk = 1'b1;
         cyc(1);
         dbg_clk = 1'b0;
         cyc(4);
      end
      send_bits(w, 11, 0, got, bad);
      check(pv_n == pv0 + 1, "R2 count", 32'(pv_n - pv0), 1);
      check(last_pkt == w, "R2 packet", 32'(last_pkt), 32'(w));

      // R1 reset mid-packet, R10 zeros after reset
      send_bits(17'h1FFFF, 16, 11, got, bad);
      dbg_clk = 1'b0;
      rst = 1'b1;
      pv0 = pv_n;
      cyc(3);
      check(dout == 1'b0 && {pstat, pdata} == 17'h0, "R1 reset again",
            32'({dout, pstat, pdata}), 0);
      rst = 1'b0;
      cyc(3);
      w = 17'h06A3C;
      send_bits(w, 16, 0, got, bad);
      check(pv_n == pv0 + 1 && last_pkt == w, "R1 counter cleared", 32'(last_pkt), 32'(w));
      check(got == 17'h0, "R10 zeros after reset", 32'(got), 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule